// File: doc/BRIEF.md
# Skip Condition Evaluator

This block decides whether a skip-group instruction should make the program counter step past the next instruction. When the decode stage raises a strobe with the instruction's address field, the block looks at the conditions that field selects. These are the accumulator value, the in-out register sign, the overflow flip-flop, six console sense switches and six program flags. One clock later it issues a single-cycle skip pulse if any selected condition holds.

The block also holds the overflow flip-flop. The arithmetic unit raises a set request whenever an add, subtract or divide exceeds the accumulator's range. Two things clear the flag: the start switch, and any skip instruction that tests the overflow bit. A test of that bit therefore both samples the flag and clears it, so one test can cover a whole run of arithmetic.

Top module: `skip_eval`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, `skip_pulse` and `ovf` are both 0.
- R2: Address bit 6 (octal 100) selects a test for a plus-zero accumulator: the condition holds only when all accumulator bits are 0.
- R3: Address bit 7 (octal 200) holds when the accumulator sign (its top bit) is 0. Address bit 8 (octal 400) holds when that sign is 1.
- R4: Address bit 9 (octal 1000) holds when `ovf` is 0, evaluated on the flag's value before this instruction. Executing it clears `ovf` one cycle later.
- R5: Address bit 10 (octal 2000) holds when `io_sign` is 0.
- R6: Address bits 5:3 form a switch code. A code n from 1 to 6 holds when `sense_sw[n-1]` is 0. Code 7 holds only when all six switches are 0. Code 0 selects no switch.
- R7: Address bits 2:0 form a flag code. A code n from 1 to 6 holds when `prog_flag[n-1]` is 0. Code 7 holds only when all six flags are 0. Code 0 selects no flag.
- R8: The skip decision is the OR of all selected conditions. An address that selects nothing never skips.
- R9: `skip_pulse` is high for exactly the one cycle after a cycle with `skp_valid` high and a true decision. It never rises without a strobe in the previous cycle.
- R10: `ovf_set` makes `ovf` 1 in the next cycle. With no set, start or overflow test, `ovf` holds its value.
- R11: When `ovf_set` and an overflow-testing skip arrive in the same cycle, `ovf` becomes 1.
- R12: `start_clr` makes `ovf` 0 in the next cycle and overrides a simultaneous `ovf_set`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| skp_valid | input | 1 | A skip-group instruction is executing this cycle |
| skp_addr | input | 12 | Address field of the skip instruction |
| ac | input | 36 | Accumulator contents |
| io_sign | input | 1 | Sign bit of the in-out register |
| sense_sw | input | 6 | Console sense switches, bit 0 is switch 1 |
| prog_flag | input | 6 | Program flags, bit 0 is flag 1 |
| ovf_set | input | 1 | Overflow request from the arithmetic unit |
| start_clr | input | 1 | Start-switch clear of the overflow flag |
| skip_pulse | output | 1 | One-cycle request to advance the program counter one extra place |
| ovf | output | 1 | Overflow flip-flop state |

## Verification
The assertions check the overflow flag on every cycle:
- its priority between set, start clear and test clear;
- that it holds its value when nothing acts on it.

They also check that a skip pulse always follows a strobe, never lasts two cycles without a strobe behind each, and appears whenever a selected accumulator-zero test holds. Only the bench's scenarios show that each switch and flag code picks the right bit and that code 7 needs every bit to be zero. They also show that combined address fields OR their conditions, and that the overflow test reads the flag before clearing it.

// File: rtl/skip_eval_pkg.sv
package skip_eval_pkg;
  // Decoded positions inside the skip address field.
  localparam int unsigned FIELD_W     = 3;
  localparam int unsigned FLAG_LSB    = 0;
  localparam int unsigned SW_LSB      = 3;
  localparam int unsigned BIT_AC_ZERO = 6;
  localparam int unsigned BIT_AC_POS  = 7;
  localparam int unsigned BIT_AC_NEG  = 8;
  localparam int unsigned BIT_OVF_CLR = 9;
  localparam int unsigned BIT_IO_POS  = 10;

  typedef enum int unsigned {
    C_AC_ZERO = 0,
    C_AC_POS  = 1,
    C_AC_NEG  = 2,
    C_OVF_CLR = 3,
    C_IO_POS  = 4,
    C_SWITCH  = 5,
    C_FLAG    = 6,
    C_COUNT   = 7
  } cond_e;

  localparam int unsigned NCOND = C_COUNT;

  function automatic logic is_plus_zero(input logic [63:0] v);
    return (v == 64'd0);
  endfunction
endpackage

// File: rtl/skip_field_sel.sv
module skip_field_sel #(
  parameter int unsigned CODE_W = 3,
  parameter int unsigned NBITS  = 6
) (
  input  logic [CODE_W-1:0] code,
  input  logic [NBITS-1:0]  bits,
  output logic              hit
);
  localparam logic [CODE_W-1:0] ALL_CODE = {CODE_W{1'b1}};

  logic [NBITS-1:0] one_hit;
  logic             all_hit;

  for (genvar i = 0; i < NBITS; i++) begin : g_one
    assign one_hit[i] = (code == CODE_W'(i + 1)) && !bits[i];
  end

  assign all_hit = (code == ALL_CODE) && !(|bits);
  assign hit     = (|one_hit) || all_hit;
endmodule

// File: rtl/skip_cond_decode.sv
module skip_cond_decode
  import skip_eval_pkg::*;
#(
  parameter int unsigned AC_W   = 36,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned NSW    = 6,
  parameter int unsigned NFLAG  = 6
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [AC_W-1:0]   ac,
  input  logic              io_sign,
  input  logic              ovf,
  input  logic [NSW-1:0]    sense_sw,
  input  logic [NFLAG-1:0]  prog_flag,
  output logic [NCOND-1:0]  hits
);
  logic ac_sign;
  logic sw_hit;
  logic flag_hit;
  logic unused_hi;

  assign ac_sign   = ac[AC_W-1];
  assign unused_hi = ^addr[ADDR_W-1:BIT_IO_POS+1];

  skip_field_sel #(.CODE_W(FIELD_W), .NBITS(NSW)) u_sw_sel (
    .code (addr[SW_LSB +: FIELD_W]),
    .bits (sense_sw),
    .hit  (sw_hit)
  );

  skip_field_sel #(.CODE_W(FIELD_W), .NBITS(NFLAG)) u_flag_sel (
    .code (addr[FLAG_LSB +: FIELD_W]),
    .bits (prog_flag),
    .hit  (flag_hit)
  );

  always_comb begin
    hits            = '0;
    hits[C_AC_ZERO] = addr[BIT_AC_ZERO] && is_plus_zero(64'(ac));
    hits[C_AC_POS]  = addr[BIT_AC_POS]  && !ac_sign;
    hits[C_AC_NEG]  = addr[BIT_AC_NEG]  &&  ac_sign;
    hits[C_OVF_CLR] = addr[BIT_OVF_CLR] && !ovf;
    hits[C_IO_POS]  = addr[BIT_IO_POS]  && !io_sign;
    hits[C_SWITCH]  = sw_hit;
    hits[C_FLAG]    = flag_hit;
  end
endmodule

// File: rtl/skip_ovf_flag.sv
module skip_ovf_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic test_clr,
  input  logic start_clr,
  output logic ovf
);
  always_ff @(posedge clk) begin
    if (!rst_n)         ovf <= 1'b0;
    else if (start_clr) ovf <= 1'b0;
    else if (set_req)   ovf <= 1'b1;
    else if (test_clr)  ovf <= 1'b0;
  end
endmodule

// File: rtl/skip_eval.sv
module skip_eval
  import skip_eval_pkg::*;
#(
  parameter int unsigned AC_W   = 36,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned NSW    = 6,
  parameter int unsigned NFLAG  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              skp_valid,
  input  logic [ADDR_W-1:0] skp_addr,
  input  logic [AC_W-1:0]   ac,
  input  logic              io_sign,
  input  logic [NSW-1:0]    sense_sw,
  input  logic [NFLAG-1:0]  prog_flag,
  input  logic              ovf_set,
  input  logic              start_clr,
  output logic              skip_pulse,
  output logic              ovf
);
  logic [NCOND-1:0] cond_hits;
  logic             any_hit;
  logic             szo_exec;

  skip_cond_decode #(
    .AC_W(AC_W), .ADDR_W(ADDR_W), .NSW(NSW), .NFLAG(NFLAG)
  ) u_decode (
    .addr      (skp_addr),
    .ac        (ac),
    .io_sign   (io_sign),
    .ovf       (ovf),
    .sense_sw  (sense_sw),
    .prog_flag (prog_flag),
    .hits      (cond_hits)
  );

  assign any_hit  = |cond_hits;
  assign szo_exec = skp_valid && skp_addr[BIT_OVF_CLR];

  skip_ovf_flag u_ovf (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_req   (ovf_set),
    .test_clr  (szo_exec),
    .start_clr (start_clr),
    .ovf       (ovf)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) skip_pulse <= 1'b0;
    else        skip_pulse <= skp_valid && any_hit;
  end
endmodule

// File: rtl/skip_eval_chk.sv
module skip_eval_chk #(
  parameter int unsigned AC_W   = 36,
  parameter int unsigned ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              skp_valid,
  input logic [ADDR_W-1:0] skp_addr,
  input logic [AC_W-1:0]   ac,
  input logic              ovf_set,
  input logic              start_clr,
  input logic              skip_pulse,
  input logic              ovf
);
  logic szo;
  assign szo = skp_valid && skp_addr[9];

  AST_PULSE_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    skip_pulse |-> $past(skp_valid)); // R9
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (skip_pulse && !skp_valid) |=> !skip_pulse); // R9
  AST_ZERO_AC_SKIPS: assert property (@(posedge clk) disable iff (!rst_n)
    (skp_valid && skp_addr[6] && ac == '0) |=> skip_pulse); // R2
  AST_EMPTY_NO_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    (skp_valid && skp_addr[10:0] == '0) |=> !skip_pulse); // R8
  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_set && !start_clr) |=> ovf); // R10
  AST_SET_BEATS_TEST: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_set && szo && !start_clr) |=> ovf); // R11
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start_clr |=> !ovf); // R12
  AST_TEST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (szo && !ovf_set && !start_clr) |=> !ovf); // R4
  AST_OVF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovf_set && !start_clr && !szo) |=> $stable(ovf)); // R10
endmodule

bind skip_eval skip_eval_chk #(.AC_W(AC_W), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .skp_valid  (skp_valid),
  .skp_addr   (skp_addr),
  .ac         (ac),
  .ovf_set    (ovf_set),
  .start_clr  (start_clr),
  .skip_pulse (skip_pulse),
  .ovf        (ovf)
);

// File: tb/tb_skip_eval.sv
module tb_skip_eval;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        skp_valid = 1'b0;
  logic [11:0] skp_addr = '0;
  logic [35:0] ac = '0;
  logic        io_sign = 1'b0;
  logic [5:0]  sense_sw = '0;
  logic [5:0]  prog_flag = '0;
  logic        ovf_set = 1'b0;
  logic        start_clr = 1'b0;
  logic        skip_pulse;
  logic        ovf;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  skip_eval dut (
    .clk(clk), .rst_n(rst_n), .skp_valid(skp_valid), .skp_addr(skp_addr),
    .ac(ac), .io_sign(io_sign), .sense_sw(sense_sw), .prog_flag(prog_flag),
    .ovf_set(ovf_set), .start_clr(start_clr), .skip_pulse(skip_pulse), .ovf(ovf)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic [11:0] addr;
    logic [35:0] acv;
    logic        io;
    logic [5:0]  sw;
    logic [5:0]  flg;
    logic        ovf_pre;
    logic        exp;
  } vec_t;

  localparam logic [35:0] NEG = 36'h8_0000_0005;
  localparam int NV = 25;
  localparam vec_t VECS [NV] = '{
    '{4'd2,  12'o0100, 36'd0,  1'b1, 6'o77, 6'o77, 1'b0, 1'b1}, // R2 plus zero
    '{4'd2,  12'o0100, 36'd5,  1'b1, 6'o77, 6'o77, 1'b0, 1'b0}, // R2
    '{4'd2,  12'o0100, {36{1'b1}}, 1'b1, 6'o77, 6'o77, 1'b0, 1'b0}, // R2 minus zero
    '{4'd3,  12'o0200, 36'd5,  1'b1, 6'o77, 6'o77, 1'b0, 1'b1}, // R3
    '{4'd3,  12'o0200, NEG,    1'b1, 6'o77, 6'o77, 1'b0, 1'b0}, // R3
    '{4'd3,  12'o0400, NEG,    1'b1, 6'o77, 6'o77, 1'b0, 1'b1}, // R3
    '{4'd3,  12'o0400, 36'd5,  1'b1, 6'o77, 6'o77, 1'b0, 1'b0}, // R3
    '{4'd4,  12'o1000, 36'd5,  1'b1, 6'o77, 6'o77, 1'b0, 1'b1}, // R4
    '{4'd4,  12'o1000, 36'd5,  1'b1, 6'o77, 6'o77, 1'b1, 1'b0}, // R4
    '{4'd5,  12'o2000, 36'd5,  1'b0, 6'o77, 6'o77, 1'b1, 1'b1}, // R5
    '{4'd5,  12'o2000, 36'd5,  1'b1, 6'o77, 6'o77, 1'b1, 1'b0}, // R5
    '{4'd6,  12'o0030, 36'd5,  1'b1, 6'b111011, 6'o77, 1'b1, 1'b1}, // R6 switch 3
    '{4'd6,  12'o0030, 36'd5,  1'b1, 6'b000100, 6'o77, 1'b1, 1'b0}, // R6
    '{4'd6,  12'o0070, 36'd5,  1'b1, 6'b000000, 6'o77, 1'b1, 1'b1}, // R6 all
    '{4'd6,  12'o0070, 36'd5,  1'b1, 6'b100000, 6'o77, 1'b1, 1'b0}, // R6 all
    '{4'd6,  12'o0060, 36'd5,  1'b1, 6'b011111, 6'o77, 1'b1, 1'b1}, // R6 switch 6
    '{4'd7,  12'o0005, 36'd5,  1'b1, 6'o77, 6'b101111, 1'b1, 1'b1}, // R7 flag 5
    '{4'd7,  12'o0005, 36'd5,  1'b1, 6'o77, 6'b010000, 1'b1, 1'b0}, // R7
    '{4'd7,  12'o0007, 36'd5,  1'b1, 6'o77, 6'b000000, 1'b1, 1'b1}, // R7 all
    '{4'd7,  12'o0007, 36'd5,  1'b1, 6'o00, 6'b000001, 1'b1, 1'b0}, // R7, R6 code 0
    '{4'd8,  12'o0000, 36'd0,  1'b0, 6'o00, 6'o00, 1'b0, 1'b0}, // R8 nothing
    '{4'd8,  12'o3000, 36'd5,  1'b1, 6'o77, 6'o77, 1'b1, 1'b0}, // R8
    '{4'd8,  12'o3000, 36'd5,  1'b0, 6'o77, 6'o77, 1'b1, 1'b1}, // R8
    '{4'd8,  12'o0700, 36'd5,  1'b1, 6'o77, 6'o77, 1'b1, 1'b1}, // R8
    '{4'd8,  12'o0077, 36'd5,  1'b1, 6'o77, 6'o00, 1'b1, 1'b1}  // R8
  };

  task automatic check(input logic got, input logic exp, input string req, input string what);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: got=%b exp=%b", req, what, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // Strobe one skip instruction; result is sampled just after the next edge.
  task automatic do_skip(input logic [11:0] a);
    @(negedge clk);
    skp_addr  = a;
    skp_valid = 1'b1;
    @(posedge clk); #1;
  endtask

  task automatic idle();
    @(negedge clk);
    skp_valid = 1'b0;
    ovf_set   = 1'b0;
    start_clr = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: got=hung exp=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(skip_pulse, 1'b0, "R1", "skip_pulse in reset");
    check(ovf, 1'b0, "R1", "ovf in reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check(skip_pulse, 1'b0, "R1", "skip_pulse after reset");
    check(ovf, 1'b0, "R1", "ovf after reset");

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      ovf_set   = VECS[i].ovf_pre;
      start_clr = !VECS[i].ovf_pre;
      idle();
      ac        = VECS[i].acv;
      io_sign   = VECS[i].io;
      sense_sw  = VECS[i].sw;
      prog_flag = VECS[i].flg;
      do_skip(VECS[i].addr);
      check(skip_pulse, VECS[i].exp, $sformatf("R%0d", VECS[i].req),
            $sformatf("vector %0d", i));
      idle();
    end

    // R9: the pulse lasts one cycle only.
    ac = '0;
    do_skip(12'o0100);
    idle();
    @(posedge clk); #1;
    check(skip_pulse, 1'b0, "R9", "pulse drops after one cycle");
    // R9: no strobe means no pulse, even with a true condition on the bus.
    skp_addr = 12'o0100;
    @(posedge clk); #1;
    check(skip_pulse, 1'b0, "R9", "no strobe no pulse");

    // R10: the set request raises the flag, which then holds.
    @(negedge clk); ovf_set = 1'b1;
    @(posedge clk); #1;
    check(ovf, 1'b1, "R10", "set raises ovf");
    idle();
    repeat (3) @(posedge clk);
    #1;
    check(ovf, 1'b1, "R10", "ovf holds");

    // R4: the test reads the flag before clearing it.
    do_skip(12'o1000);
    check(skip_pulse, 1'b0, "R4", "skip sees old ovf=1");
    check(ovf, 1'b0, "R4", "test clears ovf");
    idle();
    do_skip(12'o1000);
    check(skip_pulse, 1'b1, "R4", "second test skips");
    idle();

    // R11: set and test together leave the flag set.
    @(negedge clk);
    ovf_set   = 1'b1;
    skp_addr  = 12'o1000;
    skp_valid = 1'b1;
    @(posedge clk); #1;
    check(ovf, 1'b1, "R11", "set beats test clear");
    check(skip_pulse, 1'b1, "R11", "skip from pre-set ovf=0");
    idle();

    // R12: start clear beats a simultaneous set.
    @(negedge clk);
    ovf_set   = 1'b1;
    start_clr = 1'b1;
    @(posedge clk); #1;
    check(ovf, 1'b0, "R12", "start beats set");
    idle();

    finish_run();
  end
endmodule